// File: doc/BRIEF.md
# Three-Phase Lookup Sine Generator

This block produces three stepped sine waveforms, one per phase of a three-phase source, as sample words for external DACs. A frequency word sets how fast a fractional accumulator overflows. Each overflow is one sample-rate strobe, and the strobe rate is 256 times the wanted output frequency. Every strobe moves a single 8-bit address counter forward by one. The counter addresses three sine tables at the same moment, so each output period holds exactly 256 samples.

The tables are separate memories. The phase shift between the outputs comes only from what each table stores: every table is read at the same address, and no per-phase address offset is applied. The frequency word is clamped to a window set by parameters, which keeps the output inside the 45 Hz to 500 Hz range for the chosen clock. A period meter counts clock cycles between wraps of the address counter. It therefore measures the fundamental directly from the reference and not from the table data.

Top module: `threephase_sine_gen`

## Requirements
- R1: A single ADDR_W-bit (default 8) address counter feeds all three tables. Each strobe advances it by exactly one, wrapping from 2^ADDR_W-1 to 0. Without a strobe it holds, so one output period spans 2^ADDR_W samples.
- R2: On every clock edge, an ACC_W-bit accumulator adds the clamped frequency word modulo 2^ACC_W. The strobe register takes the carry out of that addition, and the address counter advances on the edge that follows a cycle in which the strobe is high.
- R3: A frequency word below FW_MIN is used as FW_MIN, and one above FW_MAX is used as FW_MAX. Consecutive strobes are therefore never closer than floor(2^ACC_W/FW_MAX) cycles and never further apart than ceil(2^ACC_W/FW_MIN) cycles.
- R4: Entry i of the table for phase k (A=0, B=1, C=2) is floor(M/2 + (M/2)*sin(2*pi*(i/2^ADDR_W - k/3)) + 0.5), where M = 2^DATA_W-1, in offset binary. Phase B thus lags A by 120 degrees and C lags A by 240 degrees.
- R5: On each clock edge, every sample output registers its table entry at the address held before that edge. All three outputs change together, one cycle after the address moves, and they hold while the address holds.
- R6: When the counter wraps, the period output takes the number of clock edges since the previous wrap, or since reset for the first wrap, saturating at 2^PER_W-1. At any other time the period output holds.
- R7: A synchronous reset clears the accumulator, the strobe, the address, the cycle count and the period output to 0. While reset is held, the sample outputs present the address-0 table entries from the second reset cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | ACC_W | Accumulator increment selecting the output frequency |
| sample_a | output | DATA_W | Registered phase A sample, offset binary |
| sample_b | output | DATA_W | Registered phase B sample, offset binary |
| sample_c | output | DATA_W | Registered phase C sample, offset binary |
| period_cycles | output | PER_W | Clock cycles in the last full output period |

## Verification
The bound checker checks on every cycle that the address moves only by one and only after a strobe. It also checks that strobe spacing stays inside the window the clamp allows, that the samples and the period output hold when they should, and that reset returns the address to zero. The actual table contents, with their 120 and 240 degree lags, the exact period values, and the way out-of-range words are clamped are shown only by the bench. The bench runs a cycle model of its own over directed and random frequency words and compares every output on every cycle.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  localparam real TAU = 6.283185307179586;

  // Offset-binary sine code for one table entry (R4).
  function automatic int sine_code(input int phase, input int idx,
                                   input int aw, input int dw);
    real full;
    real mid;
    real ang;
    int  r;
    full = real'((1 << dw) - 1);
    mid  = full / 2.0;
    ang  = TAU * (real'(idx) / real'(1 << aw) - real'(phase) / 3.0);
    r    = $rtoi($floor(mid + mid * $sin(ang) + 0.5));
    if (r < 0) r = 0;
    if (r > (1 << dw) - 1) r = (1 << dw) - 1;
    return r;
  endfunction

endpackage

// File: rtl/tsg_rate_gen.sv
module tsg_rate_gen #(
  parameter int          ACC_W  = 32,
  parameter int unsigned FW_MIN = 989561,
  parameter int unsigned FW_MAX = 10995116
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq_word,
  output logic             adv
);
  localparam logic [ACC_W-1:0] LO = ACC_W'(FW_MIN);
  localparam logic [ACC_W-1:0] HI = ACC_W'(FW_MAX);

  logic [ACC_W-1:0] fw_c;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             adv_q;

  // R3: clamp the frequency word into the legal window
  always_comb begin
    if (freq_word < LO)      fw_c = LO;
    else if (freq_word > HI) fw_c = HI;
    else                     fw_c = freq_word;
  end

  assign sum = {1'b0, acc_q} + {1'b0, fw_c};

  // R2: carry out of the accumulator becomes the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      adv_q <= 1'b0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      adv_q <= sum[ACC_W];
    end
  end

  assign adv = adv_q;
endmodule

// File: rtl/tsg_addr_ctr.sv
module tsg_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] addr_q;

  // R1: one shared counter, one step per strobe
  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (adv) addr_q <= addr_q + 1'b1;
  end

  assign addr = addr_q;
  assign wrap = adv && (addr_q == LAST);
endmodule

// File: rtl/tsg_period_meter.sv
module tsg_period_meter #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  output logic [PER_W-1:0] period
);
  localparam logic [PER_W-1:0] TOP = '1;

  logic [PER_W-1:0] cyc_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cyc_inc;

  assign cyc_inc = (cyc_q == TOP) ? TOP : cyc_q + 1'b1;

  // R6: latch the cycle count at each counter wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      per_q <= '0;
    end else if (wrap) begin
      per_q <= cyc_inc;
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_inc;
    end
  end

  assign period = per_q;
endmodule

// File: rtl/tsg_phase_rom.sv
module tsg_phase_rom #(
  parameter int PHASE  = 0,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic [DATA_W-1:0] dout_q;

  // R4: table contents carry the phase lag
  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DATA_W'(tsg_pkg::sine_code(PHASE, i, ADDR_W, DATA_W));
  end

  // R5: synchronous read doubles as the output register
  always_ff @(posedge clk) begin
    dout_q <= mem[addr];
  end

  assign dout = dout_q;
endmodule

// File: rtl/threephase_sine_gen.sv
module threephase_sine_gen #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter int          ACC_W  = 32,
  parameter int unsigned FW_MIN = 989561,
  parameter int unsigned FW_MAX = 10995116,
  parameter int          PER_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  freq_word,
  output logic [DATA_W-1:0] sample_a,
  output logic [DATA_W-1:0] sample_b,
  output logic [DATA_W-1:0] sample_c,
  output logic [PER_W-1:0]  period_cycles
);
  localparam int NPH = 3;

  logic              adv;
  logic              wrap;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] smp [NPH];

  tsg_rate_gen #(
    .ACC_W(ACC_W), .FW_MIN(FW_MIN), .FW_MAX(FW_MAX)
  ) u_rate (
    .clk(clk), .rst(rst), .freq_word(freq_word), .adv(adv)
  );

  tsg_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .adv(adv), .addr(addr), .wrap(wrap)
  );

  tsg_period_meter #(.PER_W(PER_W)) u_per (
    .clk(clk), .rst(rst), .wrap(wrap), .period(period_cycles)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    tsg_phase_rom #(
      .PHASE(k), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_rom (
      .clk(clk), .addr(addr), .dout(smp[k])
    );
  end

  assign sample_a = smp[0];
  assign sample_b = smp[1];
  assign sample_c = smp[2];
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter int          ACC_W  = 32,
  parameter int unsigned FW_MIN = 989561,
  parameter int unsigned FW_MAX = 10995116,
  parameter int          PER_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              adv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] sample_a,
  input logic [DATA_W-1:0] sample_b,
  input logic [DATA_W-1:0] sample_c,
  input logic [PER_W-1:0]  period_cycles
);
  localparam longint unsigned SPAN = 64'd1 << ACC_W;
  localparam logic [ACC_W:0] GAP_LO = (ACC_W+1)'(SPAN / FW_MAX - 1);
  localparam logic [ACC_W:0] GAP_HI = (ACC_W+1)'((SPAN + FW_MIN - 1) / FW_MIN);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ACC_W:0] gap;
  logic [1:0]     wcnt;
  logic           warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      wcnt <= '0;
    end else begin
      if (adv)        gap  <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
      if (wcnt != 2'd3) wcnt <= wcnt + 1'b1;
    end
  end

  assign warm = (wcnt >= 2'd2);

  p_addr_step_r1: assert property (@(posedge clk) disable iff (rst)
    adv |=> addr == $past(addr) + 1'b1);

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(addr));

  p_gap_min_r3: assert property (@(posedge clk) disable iff (rst)
    adv |-> gap >= GAP_LO);

  p_gap_max_r3: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_HI);

  p_sample_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (warm && $stable(addr)) |=>
      ($stable(sample_a) && $stable(sample_b) && $stable(sample_c)));

  p_period_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(adv && addr == LAST) |=> $stable(period_cycles));

  p_period_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && addr == LAST) |=> period_cycles != '0);

  p_reset_addr_r7: assert property (@(posedge clk)
    rst |=> (addr == '0 && !adv));
endmodule

bind threephase_sine_gen tsg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_W(ACC_W),
  .FW_MIN(FW_MIN), .FW_MAX(FW_MAX), .PER_W(PER_W)
) u_tsg_chk (
  .clk(clk), .rst(rst), .adv(adv), .addr(addr),
  .sample_a(sample_a), .sample_b(sample_b), .sample_c(sample_c),
  .period_cycles(period_cycles)
);

// File: tb/test_threephase_sine_gen.sv
`timescale 1ns/1ps
module test_threephase_sine_gen;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int ACW   = 16;
  localparam int FWLO  = 64;
  localparam int FWHI  = 4096;
  localparam int PW    = 24;
  localparam int DEPTH = 1 << AW;
  localparam int LIMIT = 200000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [ACW-1:0] freq_word = 16'd4096;
  logic [DW-1:0]  sample_a, sample_b, sample_c;
  logic [PW-1:0]  period_cycles;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  int tbl [3][DEPTH];
  int m_acc = 0, m_adv = 0, m_addr = 0, m_cyc = 0, m_per = 0;
  int m_smp [3];

  always #2.5 clk = ~clk;

  threephase_sine_gen #(
    .ADDR_W(AW), .DATA_W(DW), .ACC_W(ACW),
    .FW_MIN(FWLO), .FW_MAX(FWHI), .PER_W(PW)
  ) i_threephase_sine_gen (
    .clk(clk), .rst(rst), .freq_word(freq_word),
    .sample_a(sample_a), .sample_b(sample_b), .sample_c(sample_c),
    .period_cycles(period_cycles)
  );

  function automatic int ref_sine(int ph, int i);
    real top, half, a;
    int v;
    top  = real'((1 << DW) - 1);
    half = top / 2.0;
    a    = 6.283185307179586 * (real'(i) / real'(DEPTH) - real'(ph) / 3.0);
    v    = $rtoi($floor(half + half * $sin(a) + 0.5));
    if (v < 0) v = 0;
    if (v > (1 << DW) - 1) v = (1 << DW) - 1;
    return v;
  endfunction

  function automatic int clampw(int w);
    if (w < FWLO) return FWLO;
    if (w > FWHI) return FWHI;
    return w;
  endfunction

  function automatic int satp(int v);
    if (v > (1 << PW) - 1) return (1 << PW) - 1;
    return v;
  endfunction

  // Reference cycle model built from R2, R3, R5, R6, R7
  always @(posedge clk) begin
    int s;
    for (int k = 0; k < 3; k++) m_smp[k] <= tbl[k][m_addr];
    if (rst) begin
      m_acc <= 0; m_adv <= 0; m_addr <= 0; m_cyc <= 0; m_per <= 0;
    end else begin
      s = m_acc + clampw(int'(freq_word));
      m_acc <= s % (1 << ACW);
      m_adv <= (s >= (1 << ACW)) ? 1 : 0;
      if (m_adv == 1) m_addr <= (m_addr + 1) % DEPTH;
      if (m_adv == 1 && m_addr == DEPTH - 1) begin
        m_per <= satp(m_cyc + 1);
        m_cyc <= 0;
      end else begin
        m_cyc <= satp(m_cyc + 1);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Continuous comparison against the model on falling edges
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R4 R5 phase A sample", int'(sample_a), m_smp[0]);
      chk("R4 R5 phase B sample", int'(sample_b), m_smp[1]);
      chk("R4 R5 phase C sample", int'(sample_c), m_smp[2]);
      chk("R2 R6 period", int'(period_cycles), m_per);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk("R7 reset sample A", int'(sample_a), tbl[0][0]);
    chk("R7 reset sample B", int'(sample_b), tbl[1][0]);
    chk("R7 reset sample C", int'(sample_c), tbl[2][0]);
    chk("R7 reset period", int'(period_cycles), 0);
  endtask

  initial begin
    #(LIMIT * 5.0);
    fails++;
    $display("FAIL watchdog expired after %0d cycles", LIMIT);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'd4177));
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < DEPTH; i++) tbl[k][i] = ref_sine(k, i);

    // R4: phase lag sanity at known addresses (A peak near 64, B at 0 below mid)
    chk("R4 A at quarter", tbl[0][DEPTH/4], (1 << DW) - 1);
    chk("R4 C sits above mid at 0", (tbl[2][0] > tbl[0][0]) ? 1 : 0, 1);

    // R7: reset state
    rst = 1'b1;
    run(4);
    check_reset_state();
    rst = 1'b0;
    cmp_on = 1'b1;

    // R1 R2: top frequency, one output period = 256 strobes of 16 cycles
    freq_word = 16'd4096;
    run(9000);
    chk("R1 R6 period at top word", int'(period_cycles), 4096);

    // R3: oversize word clamps to the top
    freq_word = 16'hFFFF;
    run(9000);
    chk("R3 R6 period with clamped high word", int'(period_cycles), 4096);

    // R3: zero word clamps to the bottom (checked against model)
    freq_word = 16'd0;
    run(3000);

    // R2: exact divisor, 2048 -> 32 cycles per strobe
    freq_word = 16'd2048;
    run(17000);
    chk("R2 R6 period at half word", int'(period_cycles), 8192);

    // Random words, some outside the window (R3)
    for (int seg = 0; seg < 8; seg++) begin
      if (seg % 4 == 3) w = int'($urandom % 65536);
      else              w = FWLO + int'($urandom % (FWHI - FWLO + 1));
      freq_word = ACW'(w);
      run(3000 + int'($urandom % 3000));
    end

    // R7: mid-run reset
    rst = 1'b1;
    run(3);
    check_reset_state();
    rst = 1'b0;
    freq_word = 16'd3000;
    run(5000);

    cmp_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule